// File: doc/BRIEF.md
# Monitor channel handshake controller

This block moves bytes over the monitor slot of a framed serial bus. Every frame gives the slot one data byte and two handshake lines. The transmit-valid line (MX) is idle high, and 0 means a byte is being offered. The receive-acknowledge line (MR) is also idle high, and 0 means a byte has been taken. Frames arrive at a fixed rate, marked by a one-cycle `frame_i` strobe. The flow of bytes, however, is paced only by the handshake. A byte is offered again in every frame until the far end takes it.

The transmitter takes a byte from software and holds it on the line with MX active until it sees an acknowledge. It then waits for the next byte or for an end command. The receiver looks at every incoming frame. It accepts a byte once it has seen the same byte in two frames in a row, and it acknowledges with a single frame of MR active. Four sticky status flags report events to software, each with its own interrupt enable. One enable input per direction can force that direction's handshake line to idle.

Top module: `mon_chan_ctrl`

## Requirements
- R1: After reset `tx_mx_o` and `tx_mr_o` are 1, `tx_active_o` is 0, `status_o` is 0 and `irq_o` is 0.
- R2: With `rx_hs_en_i`=1, a byte is captured into `rx_byte_o` and sets status bit 0 (data received) at a frame strobe when two conditions hold. First, `rx_mx_i` is 0 with the same `rx_data_i` as in the previous frame. Second, `rx_mx_i` has been 1 since the last capture, or the byte differs from the last captured byte. A byte seen in only one frame is never captured.
- R3: `tx_mr_o` goes to 0 at the frame strobe that captures a byte, and returns to 1 at the next frame strobe.
- R4: After at least one capture, two frames in a row with `rx_mx_i`=1 set status bit 1 (end of reception).
- R5: A `tx_wr_i` pulse while the transmitter is idle loads `tx_byte_i`. It sets `tx_active_o`, drives `tx_mx_o` to 0, and presents the byte on `tx_data_o` until it is acknowledged.
- R6: While a byte is awaiting acknowledge, a frame with `rx_mr_i`=0 whose previous frame had `rx_mr_i`=1 sets status bit 2 (acknowledged). `tx_mx_o` then stays 0 and `tx_active_o` stays 1. A `tx_wr_i` pulse during the wait has no effect on `tx_data_o`.
- R7: If `ABORT_FRAMES` frames pass while awaiting acknowledge with no acknowledge, status bit 3 (abort) is set at the last of them. `tx_mx_o` becomes 1 and `tx_active_o` becomes 0. One frame fewer leaves both unchanged.
- R8: A `tx_end_i` pulse after an acknowledge sets `tx_mx_o` to 1 at once. `tx_active_o` stays 1 through the first following frame strobe and clears at the second.
- R9: While `tx_hs_en_i`=0, `tx_mx_o` is 1. While `rx_hs_en_i`=0, `tx_mr_o` is 1 and no byte is captured.
- R10: Status bits are sticky. Writing 1 to a bit of `status_clr_i` clears that bit. `irq_o` is 1 exactly when some set status bit has its `irq_en_i` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per frame; slot inputs are sampled here |
| rx_data_i | input | 8 | Incoming monitor byte |
| rx_mx_i | input | 1 | Incoming transmit-valid, active low |
| rx_mr_i | input | 1 | Incoming acknowledge, active low |
| tx_data_o | output | 8 | Outgoing monitor byte |
| tx_mx_o | output | 1 | Outgoing transmit-valid, active low |
| tx_mr_o | output | 1 | Outgoing acknowledge, active low |
| tx_hs_en_i | input | 1 | Transmit handshake enable; 0 forces MX idle |
| rx_hs_en_i | input | 1 | Receive handshake enable; 0 forces MR idle |
| tx_byte_i | input | 8 | Byte to send |
| tx_wr_i | input | 1 | Load byte and start sending |
| tx_end_i | input | 1 | End-of-message command |
| rx_byte_o | output | 8 | Last captured byte |
| tx_active_o | output | 1 | Transmission in progress |
| status_o | output | 4 | Sticky flags: 0 received, 1 end of reception, 2 acknowledged, 3 abort |
| status_clr_i | input | 4 | Write-one-to-clear for status bits |
| irq_en_i | input | 4 | Interrupt enable per status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `frame_i` is a single-cycle pulse and that the slot inputs are steady around it. The bench therefore raises the strobe for exactly one clock and separates strobes with idle clocks. They also assume that software issues `tx_end_i` only while waiting after an acknowledge. The bench uses the end command only in that state. Received bytes are pushed into a scoreboard queue before their frames are driven, and the bench clears the received flag after each capture, so every rising edge of that flag stands for one new byte.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2,
    TX_ENDG = 2'd3
  } tx_state_e;

  localparam int STS_W    = 4;
  localparam int STS_RXD  = 0;
  localparam int STS_REND = 1;
  localparam int STS_ACK  = 2;
  localparam int STS_ABT  = 3;
endpackage

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          frame_i,
  input  logic [DW-1:0] data_i,
  input  logic          mx_i,
  output logic          mr_o,
  output logic [DW-1:0] byte_o,
  output logic          got_o,
  output logic          end_o
);
  logic          prev_mx_q, armed_q, busy_q, mr_act_q;
  logic [DW-1:0] prev_data_q, last_q;
  logic          stable_act, is_new, idle2;

  assign stable_act = !mx_i && !prev_mx_q && (data_i == prev_data_q);
  assign is_new     = armed_q || (data_i != last_q);
  assign idle2      = mx_i && prev_mx_q;
  assign got_o      = en_i && frame_i && stable_act && is_new;
  assign end_o      = en_i && frame_i && idle2 && busy_q;
  assign mr_o       = !(en_i && mr_act_q);
  assign byte_o     = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_mx_q   <= 1'b1;
      prev_data_q <= '0;
      armed_q     <= 1'b1;
      busy_q      <= 1'b0;
      mr_act_q    <= 1'b0;
      last_q      <= '0;
    end else if (frame_i) begin
      prev_mx_q   <= mx_i;
      prev_data_q <= data_i;
      if (!en_i) begin
        armed_q  <= 1'b1;
        busy_q   <= 1'b0;
        mr_act_q <= 1'b0;
      end else begin
        mr_act_q <= got_o;
        if (got_o) begin
          last_q  <= data_i;
          armed_q <= 1'b0;
          busy_q  <= 1'b1;
        end
        if (mx_i) armed_q <= 1'b1;
        if (end_o) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_pkg::*;
#(
  parameter int DW           = 8,
  parameter int ABORT_FRAMES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          frame_i,
  input  logic          mr_i,
  input  logic [DW-1:0] byte_i,
  input  logic          wr_i,
  input  logic          end_i,
  output logic [DW-1:0] data_o,
  output logic          mx_o,
  output logic          active_o,
  output logic          ack_o,
  output logic          abort_o
);
  localparam int CW = $clog2(ABORT_FRAMES + 1);

  tx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] byte_q;
  logic          mr_prev_q;
  logic          ack_seen, time_out;

  assign ack_seen = !mr_i && mr_prev_q;
  assign time_out = (cnt_q == CW'(ABORT_FRAMES - 1));
  assign ack_o    = en_i && frame_i && (state_q == TX_SEND) && ack_seen;
  assign abort_o  = en_i && frame_i && (state_q == TX_SEND) && !ack_seen && time_out;
  assign active_o = (state_q != TX_IDLE);
  assign mx_o     = !(en_i && ((state_q == TX_SEND) || (state_q == TX_WAIT)));
  assign data_o   = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      cnt_q     <= '0;
      byte_q    <= '0;
      mr_prev_q <= 1'b1;
    end else begin
      if (frame_i) mr_prev_q <= mr_i;
      if (!en_i) begin
        state_q <= TX_IDLE;
      end else begin
        unique case (state_q)
          TX_IDLE: if (wr_i) begin
            byte_q  <= byte_i;
            cnt_q   <= '0;
            state_q <= TX_SEND;
          end
          TX_SEND: if (frame_i) begin
            if (ack_seen)      state_q <= TX_WAIT;
            else if (time_out) state_q <= TX_IDLE;
            else               cnt_q   <= cnt_q + 1'b1;
          end
          TX_WAIT: if (wr_i) begin
            byte_q  <= byte_i;
            cnt_q   <= '0;
            state_q <= TX_SEND;
          end else if (end_i) begin
            cnt_q   <= '0;
            state_q <= TX_ENDG;
          end
          TX_ENDG: if (frame_i) begin
            if (cnt_q == CW'(1)) state_q <= TX_IDLE;
            else                 cnt_q   <= cnt_q + 1'b1;
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_sts.sv
module mon_sts #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] set_i,
  input  logic [SW-1:0] clr_i,
  input  logic [SW-1:0] irq_en_i,
  output logic [SW-1:0] sts_o,
  output logic          irq_o
);
  logic [SW-1:0] sts_q;

  for (genvar k = 0; k < SW; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[k] <= 1'b0;
      else if (set_i[k]) sts_q[k] <= 1'b1;
      else if (clr_i[k]) sts_q[k] <= 1'b0;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & irq_en_i);
endmodule

// File: rtl/mon_chan_ctrl.sv
module mon_chan_ctrl
  import mon_pkg::*;
#(
  parameter int DW           = 8,
  parameter int ABORT_FRAMES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_mx_i,
  input  logic             rx_mr_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_mx_o,
  output logic             tx_mr_o,
  input  logic             tx_hs_en_i,
  input  logic             rx_hs_en_i,
  input  logic [DW-1:0]    tx_byte_i,
  input  logic             tx_wr_i,
  input  logic             tx_end_i,
  output logic [DW-1:0]    rx_byte_o,
  output logic             tx_active_o,
  output logic [STS_W-1:0] status_o,
  input  logic [STS_W-1:0] status_clr_i,
  input  logic [STS_W-1:0] irq_en_i,
  output logic             irq_o
);
  logic             rx_got, rx_end, tx_ack, tx_abort;
  logic [STS_W-1:0] sts_set;

  mon_rx #(.DW(DW)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_hs_en_i),
    .frame_i(frame_i),
    .data_i (rx_data_i),
    .mx_i   (rx_mx_i),
    .mr_o   (tx_mr_o),
    .byte_o (rx_byte_o),
    .got_o  (rx_got),
    .end_o  (rx_end)
  );

  mon_tx #(.DW(DW), .ABORT_FRAMES(ABORT_FRAMES)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tx_hs_en_i),
    .frame_i (frame_i),
    .mr_i    (rx_mr_i),
    .byte_i  (tx_byte_i),
    .wr_i    (tx_wr_i),
    .end_i   (tx_end_i),
    .data_o  (tx_data_o),
    .mx_o    (tx_mx_o),
    .active_o(tx_active_o),
    .ack_o   (tx_ack),
    .abort_o (tx_abort)
  );

  always_comb begin
    sts_set           = '0;
    sts_set[STS_RXD]  = rx_got;
    sts_set[STS_REND] = rx_end;
    sts_set[STS_ACK]  = tx_ack;
    sts_set[STS_ABT]  = tx_abort;
  end

  mon_sts #(.SW(STS_W)) i_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (sts_set),
    .clr_i   (status_clr_i),
    .irq_en_i(irq_en_i),
    .sts_o   (status_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/mon_chan_chk.sv
module mon_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       tx_mx_o,
  input logic       tx_mr_o,
  input logic       tx_hs_en_i,
  input logic       rx_hs_en_i,
  input logic       tx_active_o,
  input logic [3:0] status_o
);
  // R9
  mx_forced_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_hs_en_i |-> tx_mx_o);
  // R9
  mr_forced_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_hs_en_i |-> tx_mr_o);
  // R3
  mr_one_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !tx_mr_o && rx_hs_en_i) |=> tx_mr_o);
  // R5
  mx_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_o |-> tx_mx_o);
  // R2
  rxd_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(frame_i));
  // R7
  abort_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(frame_i));
endmodule

bind mon_chan_ctrl mon_chan_chk i_mon_chan_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .tx_mx_o    (tx_mx_o),
  .tx_mr_o    (tx_mr_o),
  .tx_hs_en_i (tx_hs_en_i),
  .rx_hs_en_i (rx_hs_en_i),
  .tx_active_o(tx_active_o),
  .status_o   (status_o)
);

// File: tb/test_mon_chan_ctrl.sv
module test_mon_chan_ctrl;
  localparam int AF = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_mx_i = 1'b1, rx_mr_i = 1'b1;
  logic [7:0] tx_data_o;
  logic       tx_mx_o, tx_mr_o;
  logic       tx_hs_en_i = 1'b0, rx_hs_en_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       tx_wr_i = 1'b0, tx_end_i = 1'b0;
  logic [7:0] rx_byte_o;
  logic       tx_active_o;
  logic [3:0] status_o;
  logic [3:0] status_clr_i = '0, irq_en_i = '0;
  logic       irq_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic       rxd_prev = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mon_chan_ctrl i_mon_chan_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(logic mx, logic mr, logic [7:0] d);
    @(negedge clk_i);
    rx_mx_i = mx; rx_mr_i = mr; rx_data_i = d; frame_i = 1'b1;
    @(negedge clk_i);
    frame_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse_wr(logic [7:0] b);
    @(negedge clk_i); tx_byte_i = b; tx_wr_i = 1'b1;
    @(negedge clk_i); tx_wr_i = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk_i); tx_end_i = 1'b1;
    @(negedge clk_i); tx_end_i = 1'b0;
  endtask

  task automatic clr(logic [3:0] m);
    @(negedge clk_i); status_clr_i = m;
    @(negedge clk_i); status_clr_i = '0;
  endtask

  // scoreboard monitor: each rise of the received flag pops one expected byte
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (status_o[0] && !rxd_prev) begin
        if (exp_q.size() == 0) check("R2 unexpected capture", {24'h0, rx_byte_o}, 32'hffff);
        else check("R2 captured byte", {24'h0, rx_byte_o}, {24'h0, exp_q.pop_front()});
      end
      rxd_prev <= status_o[0];
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 mx", tx_mx_o, 1); check("R1 mr", tx_mr_o, 1);
    check("R1 active", tx_active_o, 0); check("R1 status", status_o, 0);
    check("R1 irq", irq_o, 0);
    rst_ni = 1'b1;

    // R9: receive handshake disabled
    frame(0, 1, 8'h33); frame(0, 1, 8'h33);
    check("R9 no capture", status_o[0], 0); check("R9 mr idle", tx_mr_o, 1);

    rx_hs_en_i = 1'b1;
    exp_q.push_back(8'h11);
    frame(0, 1, 8'h11);
    check("R2 one frame not enough", status_o[0], 0);
    frame(0, 1, 8'h11);
    check("R3 mr active", tx_mr_o, 0);
    clr(4'b0001);
    frame(0, 1, 8'h11);
    check("R3 mr released", tx_mr_o, 1);
    check("R2 repeat not new", status_o[0], 0);

    exp_q.push_back(8'h22);
    frame(0, 1, 8'h22); frame(0, 1, 8'h22);
    clr(4'b0001);
    // single-frame glitch byte then a stable one
    exp_q.push_back(8'h44);
    frame(0, 1, 8'h37); frame(0, 1, 8'h44); frame(0, 1, 8'h44);
    clr(4'b0001);
    check("R4 not yet", status_o[1], 0);
    frame(1, 1, 8'h00);
    check("R4 one idle frame", status_o[1], 0);
    frame(1, 1, 8'h00);
    check("R4 end of reception", status_o[1], 1);
    // same byte again after idle is new
    exp_q.push_back(8'h44);
    frame(0, 1, 8'h44); frame(0, 1, 8'h44);
    clr(4'b0011);
    frame(1, 1, 8'h00); frame(1, 1, 8'h00);
    clr(4'b0010);

    // transmitter
    pulse_wr(8'h5a);
    check("R9 tx disabled ignores write", tx_active_o, 0);
    check("R9 mx forced", tx_mx_o, 1);
    tx_hs_en_i = 1'b1;
    pulse_wr(8'h5a);
    check("R5 active", tx_active_o, 1); check("R5 mx", tx_mx_o, 0);
    check("R5 data", tx_data_o, 8'h5a);
    pulse_wr(8'h77);
    check("R6 write during send ignored", tx_data_o, 8'h5a);
    frame(1, 1, 8'h00);
    check("R5 still sending", tx_mx_o, 0);
    check("R6 no ack yet", status_o[2], 0);
    frame(1, 0, 8'h00);
    check("R6 ack", status_o[2], 1);
    check("R6 mx held", tx_mx_o, 0); check("R6 active held", tx_active_o, 1);
    pulse_end();
    check("R8 mx idle", tx_mx_o, 1); check("R8 active", tx_active_o, 1);
    frame(1, 1, 8'h00);
    check("R8 active after one frame", tx_active_o, 1);
    frame(1, 1, 8'h00);
    check("R8 active cleared", tx_active_o, 0);

    // abort
    pulse_wr(8'hc3);
    for (int i = 0; i < AF - 1; i++) frame(1, 1, 8'h00);
    check("R7 no abort early", status_o[3], 0);
    check("R7 still active", tx_active_o, 1);
    frame(1, 1, 8'h00);
    check("R7 abort", status_o[3], 1);
    check("R7 mx idle", tx_mx_o, 1); check("R7 inactive", tx_active_o, 0);

    // status and interrupt masking
    irq_en_i = 4'b0001;
    check("R10 masked irq", irq_o, 0);
    irq_en_i = 4'b1000;
    @(negedge clk_i);
    check("R10 irq", irq_o, 1);
    clr(4'b1000);
    check("R10 w1c", status_o, 4'b0100);
    check("R10 irq cleared", irq_o, 0);

    // enable drop mid-transfer
    pulse_wr(8'h99);
    tx_hs_en_i = 1'b0;
    @(negedge clk_i);
    check("R9 mx forced mid transfer", tx_mx_o, 1);

    check("R2 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule